// File: doc/BRIEF.md
# Direct-Page Effective Address Generator

This block turns an addressing-mode code, two instruction operand bytes, the two 8-bit index registers and a page-select status bit into a 16-bit effective address. The execution unit pulses `start` with the request. For the direct modes the block returns the address on `ea` with a one-cycle `done` strobe. For the two pointer modes it first fetches a 16-bit pointer through an 8-bit synchronous read port, then returns the address.

Direct-page addresses sit in page 0 or page 1, depending on the page-select bit. Register-indirect addressing uses X as the offset inside that page. The post-increment form also raises `x_inc` together with `done`, which tells the register file to bump X. The two pointer modes differ in where the index is added. In the pre-indexed mode X is added to the page offset before the pointer is read. In the post-indexed mode Y is added to the fetched pointer.

All request inputs are captured in the cycle in which `start` is accepted. A `start` that arrives while the block is busy is ignored.

Top module: `dpage_agu`

## Requirements
- R1: While reset is high and in the first cycle after it, `done`, `x_inc`, `busy` and `mem_rd_en` are 0 and `ea` is 0x0000.
- R2: Mode codes 0, 1 and 2 give direct-page addresses `{7'b0, P, off}`. The offset `off` is op_lo (code 0), op_lo+X (code 1) or op_lo+Y (code 2), and the sum wraps within 8 bits.
- R3: Mode codes 3 and 4 give `{7'b0, P, X}`. Code 4 also drives `x_inc` high in the `done` cycle. No other code ever raises `x_inc`, and `x_inc` is never high without `done`.
- R4: Mode codes 5, 6 and 7 give `{op_hi, op_lo}`, `{op_hi, op_lo}+X` or `{op_hi, op_lo}+Y`, each taken modulo 65536.
- R5: Mode code 8 (pre-indexed pointer) reads the low byte at `{7'b0, P, b}` and the high byte at `{7'b0, P, b+1}`, where b = op_lo+X and all offset sums wrap within 8 bits. The result is `ea = {high, low}`.
- R6: Mode code 9 (post-indexed pointer) reads the pointer bytes at offsets op_lo and op_lo+1 of the selected page, with wrap. The result is `ea = pointer + Y` modulo 65536.
- R7: `start` is sampled at a rising edge k. For codes 0 to 7, `done` is high in the cycle that follows edge k. For codes 8 and 9, `mem_rd_en` is high for exactly the two cycles that follow edges k and k+1, read data is taken one cycle after each read, and `done` is high in the cycle that follows edge k+3.
- R8: `busy` is high from edge k until the `done` cycle of a pointer request. It is never high together with `done`. `done` falls in the cycle after it was high unless a new request was accepted.
- R9: A `start` seen while `busy` is high has no effect, either on the address produced or on the number of memory reads.
- R10: The reserved mode codes 10 to 15 behave as code 0.
- R11: The mode, operands, X, Y and P are sampled only at the accepting edge. Changing them afterwards does not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, accepted when not busy |
| mode | input | 4 | Addressing-mode code |
| op_lo | input | 8 | First operand byte (offset or address low) |
| op_hi | input | 8 | Second operand byte (address high) |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| page_sel | input | 1 | Direct-page select bit from the status word |
| busy | output | 1 | Pointer fetch in progress |
| done | output | 1 | One-cycle result strobe |
| ea | output | 16 | Effective address, valid with done and held after it |
| x_inc | output | 1 | Request to increment X, with done |
| mem_rd_en | output | 1 | Memory read enable |
| mem_addr | output | 16 | Memory read address |
| mem_rd_data | input | 8 | Read data, valid one cycle after mem_rd_en |

## Verification
The assertions assume that memory returns data exactly one cycle after each read enable and that reset is held for at least one clock edge. Given that, the pointer reads always come as a back-to-back pair inside page 0 or 1, with the second address one offset above the first. The bench models the memory as a pure function of the address, so it always answers on time. It drives `start` only at falling edges and gives a hold of `start` during busy only to pointer requests, so a held start never reaches the block while it is idle.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    AM_DP        = 4'd0,
    AM_DP_X      = 4'd1,
    AM_DP_Y      = 4'd2,
    AM_REG_X     = 4'd3,
    AM_REG_X_INC = 4'd4,
    AM_ABS       = 4'd5,
    AM_ABS_X     = 4'd6,
    AM_ABS_Y     = 4'd7,
    AM_PRE_IND   = 4'd8,
    AM_POST_IND  = 4'd9
  } amode_e;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_LO   = 2'd1,
    FS_HI   = 2'd2,
    FS_FIN  = 2'd3
  } fetch_st_e;
endpackage

// File: rtl/agu_mode_decode.sv
module agu_mode_decode
  import agu_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic [MODE_W-1:0] mode,
  input  logic              page_sel,
  input  logic [DW-1:0]     op_lo,
  input  logic [DW-1:0]     op_hi,
  input  logic [DW-1:0]     idx_x,
  input  logic [DW-1:0]     idx_y,
  output logic              indirect,
  output logic              x_bump,
  output logic [AW-1:0]     direct_ea,
  output logic [DW-1:0]     ptr_off,
  output logic [DW-1:0]     post_add
);
  function automatic logic [AW-1:0] page_addr(input logic p, input logic [DW-1:0] off);
    return {{(DW-1){1'b0}}, p, off};
  endfunction

  logic [AW-1:0] abs_base;
  assign abs_base = {op_hi, op_lo};

  always_comb begin
    indirect  = 1'b0;
    x_bump    = 1'b0;
    ptr_off   = op_lo;
    post_add  = '0;
    direct_ea = page_addr(page_sel, op_lo);
    case (mode)
      AM_DP_X:      direct_ea = page_addr(page_sel, op_lo + idx_x);
      AM_DP_Y:      direct_ea = page_addr(page_sel, op_lo + idx_y);
      AM_REG_X:     direct_ea = page_addr(page_sel, idx_x);
      AM_REG_X_INC: begin
        direct_ea = page_addr(page_sel, idx_x);
        x_bump    = 1'b1;
      end
      AM_ABS:       direct_ea = abs_base;
      AM_ABS_X:     direct_ea = abs_base + {{DW{1'b0}}, idx_x};
      AM_ABS_Y:     direct_ea = abs_base + {{DW{1'b0}}, idx_y};
      AM_PRE_IND: begin
        indirect = 1'b1;
        ptr_off  = op_lo + idx_x;
      end
      AM_POST_IND: begin
        indirect = 1'b1;
        post_add = idx_y;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/agu_ptr_fetch.sv
module agu_ptr_fetch
  import agu_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          page_sel,
  input  logic [DW-1:0] ptr_off,
  input  logic [DW-1:0] post_add,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          busy,
  output logic          fin,
  output logic [AW-1:0] fin_ea
);
  fetch_st_e     st;
  logic          page_q;
  logic [DW-1:0] off_q;
  logic [DW-1:0] add_q;
  logic [DW-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= FS_IDLE;
      mem_rd_en <= 1'b0;
      mem_addr  <= '0;
      page_q    <= 1'b0;
      off_q     <= '0;
      add_q     <= '0;
      lo_q      <= '0;
    end else begin
      case (st)
        FS_IDLE: if (go) begin
          st        <= FS_LO;
          page_q    <= page_sel;
          off_q     <= ptr_off;
          add_q     <= post_add;
          mem_rd_en <= 1'b1;
          mem_addr  <= {{(DW-1){1'b0}}, page_sel, ptr_off};
        end
        FS_LO: begin
          st        <= FS_HI;
          mem_rd_en <= 1'b1;
          mem_addr  <= {{(DW-1){1'b0}}, page_q, off_q + DW'(1)};
        end
        FS_HI: begin
          st        <= FS_FIN;
          mem_rd_en <= 1'b0;
          lo_q      <= mem_rd_data;
        end
        default: st <= FS_IDLE;
      endcase
    end
  end

  assign busy   = (st != FS_IDLE);
  assign fin    = (st == FS_FIN);
  assign fin_ea = {mem_rd_data, lo_q} + {{DW{1'b0}}, add_q};

  p_page_r5: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (mem_addr[AW-1:DW+1] == '0));
  p_hi_next_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && $past(mem_rd_en)) |->
      (mem_addr == {$past(mem_addr[AW-1:DW]), $past(mem_addr[DW-1:0]) + DW'(1)}));
  p_rd_pair_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd_en) |=> mem_rd_en ##1 !mem_rd_en);
endmodule

// File: rtl/dpage_agu.sv
module dpage_agu
  import agu_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [DW-1:0]     op_lo,
  input  logic [DW-1:0]     op_hi,
  input  logic [DW-1:0]     idx_x,
  input  logic [DW-1:0]     idx_y,
  input  logic              page_sel,
  output logic              busy,
  output logic              done,
  output logic [AW-1:0]     ea,
  output logic              x_inc,
  output logic              mem_rd_en,
  output logic [AW-1:0]     mem_addr,
  input  logic [DW-1:0]     mem_rd_data
);
  logic          indirect, x_bump;
  logic [AW-1:0] direct_ea;
  logic [DW-1:0] ptr_off, post_add;
  logic          accept, fin;
  logic [AW-1:0] fin_ea;

  agu_mode_decode #(.DW(DW)) i_decode (
    .mode(mode), .page_sel(page_sel), .op_lo(op_lo), .op_hi(op_hi),
    .idx_x(idx_x), .idx_y(idx_y), .indirect(indirect), .x_bump(x_bump),
    .direct_ea(direct_ea), .ptr_off(ptr_off), .post_add(post_add)
  );

  assign accept = start && !busy;

  agu_ptr_fetch #(.DW(DW)) i_fetch (
    .clk(clk), .rst(rst), .go(accept && indirect), .page_sel(page_sel),
    .ptr_off(ptr_off), .post_add(post_add), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rd_data(mem_rd_data), .busy(busy),
    .fin(fin), .fin_ea(fin_ea)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      x_inc <= 1'b0;
      ea    <= '0;
    end else begin
      done  <= (accept && !indirect) || fin;
      x_inc <= accept && !indirect && x_bump;
      if (accept && !indirect) ea <= direct_ea;
      else if (fin)            ea <= fin_ea;
    end
  end

  p_xinc_done_r3: assert property (@(posedge clk) disable iff (rst)
    x_inc |-> done);
  p_busy_excl_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));
  p_busy_end_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  p_rd_busy_r9: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> busy);
endmodule

// File: tb/test_dpage_agu.sv
module test_dpage_agu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [7:0]  op_lo = '0, op_hi = '0, idx_x = '0, idx_y = '0;
  logic        page_sel = 1'b0;
  logic        busy, done, x_inc, mem_rd_en;
  logic [15:0] ea, mem_addr;
  logic [7:0]  mem_rd_data = '0;
  int          n_run = 0, n_fail = 0, rd_total = 0;

  always #4 clk = ~clk;

  dpage_agu i_dpage_agu (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .op_lo(op_lo),
    .op_hi(op_hi), .idx_x(idx_x), .idx_y(idx_y), .page_sel(page_sel),
    .busy(busy), .done(done), .ea(ea), .x_inc(x_inc),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5a ^ {a[3:0], a[7:4]};
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= memf(mem_addr);
      rd_total <= rd_total + 1;
    end
  end

  function automatic logic [15:0] exp_ea(input logic [3:0] m, input logic [7:0] lo, hi, x, y,
                                         input logic p);
    logic [7:0] b;
    logic [15:0] ptr;
    case (m)
      4'd1: return {7'b0, p, 8'(lo + x)};
      4'd2: return {7'b0, p, 8'(lo + y)};
      4'd3, 4'd4: return {7'b0, p, x};
      4'd5: return {hi, lo};
      4'd6: return {hi, lo} + {8'h00, x};
      4'd7: return {hi, lo} + {8'h00, y};
      4'd8, 4'd9: begin
        b   = (m == 4'd8) ? 8'(lo + x) : lo;
        ptr = {memf({7'b0, p, 8'(b + 8'd1)}), memf({7'b0, p, b})};
        return (m == 4'd9) ? ptr + {8'h00, y} : ptr;
      end
      default: return {7'b0, p, lo};
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] m);
    case (m)
      4'd0, 4'd1, 4'd2: return "R2";
      4'd3, 4'd4: return "R3";
      4'd5, 4'd6, 4'd7: return "R4";
      4'd8: return "R5";
      4'd9: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_req(input logic [3:0] m, input logic [7:0] lo, hi, x, y,
                        input logic p, input bit hold);
    logic [15:0] e;
    bit ind;
    int n, rd0;
    e   = exp_ea(m, lo, hi, x, y, p);
    ind = (m == 4'd8) || (m == 4'd9);
    @(negedge clk);
    rd0 = rd_total;
    mode = m; op_lo = lo; op_hi = hi; idx_x = x; idx_y = y; page_sel = p;
    start = 1'b1;
    n = 0;
    while (1) begin
      @(negedge clk);
      n++;
      // R11: scramble inputs after the accepting edge
      op_lo = 8'($urandom); op_hi = 8'($urandom); idx_x = 8'($urandom);
      idx_y = 8'($urandom); page_sel = 1'($urandom);
      if (hold && !done && n < 3) begin
        start = 1'b1; mode = 4'd0;   // R9: start during busy
      end else begin
        start = 1'b0;
      end
      if (done || n > 8) break;
    end
    start = 1'b0;
    chk(done, "R7", "done seen", 32'(done), 32'd1);
    chk(n == (ind ? 4 : 1), "R7", "latency", n, ind ? 4 : 1);
    chk(ea == e, req_of(m), hold ? "ea with start in busy (R9)" : "ea (R11)", ea, e);
    chk(x_inc == (m == 4'd4), "R3", "x_inc", 32'(x_inc), 32'(m == 4'd4));
    chk(!busy, "R8", "busy at done", 32'(busy), 0);
    chk(rd_total - rd0 == (ind ? 2 : 0), hold ? "R9" : "R7", "read count",
        rd_total - rd0, ind ? 2 : 0);
    @(negedge clk);
    chk(!done && !x_inc, "R8", "done pulse", 32'(done), 0);
    chk(ea == e, "R8", "ea held", ea, e);
  endtask

  initial begin
    void'($urandom(32'd20240601));
    repeat (3) @(negedge clk);
    chk(!done && !x_inc && !busy && !mem_rd_en && ea == 16'h0, "R1", "in reset",
        {ea, 12'h0, done, x_inc, busy, mem_rd_en}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !x_inc && !busy && !mem_rd_en && ea == 16'h0, "R1", "after reset",
        {ea, 12'h0, done, x_inc, busy, mem_rd_en}, 0);
    // directed corners
    do_req(4'd1, 8'hF0, 8'h00, 8'h20, 8'h00, 1'b1, 0);   // R2 page wrap
    do_req(4'd2, 8'h80, 8'h00, 8'h00, 8'h90, 1'b0, 0);   // R2
    do_req(4'd4, 8'h00, 8'h00, 8'h7F, 8'h00, 1'b1, 0);   // R3
    do_req(4'd6, 8'hF0, 8'hFF, 8'h20, 8'h00, 1'b0, 0);   // R4 wrap
    do_req(4'd8, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b1, 0);   // R5 pointer wrap
    do_req(4'd8, 8'hF0, 8'h00, 8'h10, 8'h00, 1'b0, 0);   // R5 offset wrap
    do_req(4'd9, 8'hFF, 8'h00, 8'h00, 8'hFF, 1'b0, 0);   // R6
    do_req(4'd12, 8'h34, 8'h12, 8'h05, 8'h06, 1'b1, 0);  // R10
    do_req(4'd15, 8'h01, 8'hAB, 8'h05, 8'h06, 1'b0, 0);  // R10
    do_req(4'd9, 8'h10, 8'h00, 8'h01, 8'hC0, 1'b1, 1);   // R9
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] m;
      m = 4'($urandom_range(0, 15));
      do_req(m, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
             1'($urandom), ((m == 4'd8) || (m == 4'd9)) && ($urandom_range(0, 3) == 0));
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule